// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. It accepts a start request either from a software-written start/busy bit or from an active-low external trigger pin. It divides the system clock by a programmable factor to form the conversion clock and steps through a fixed sixteen-tick conversion. During that conversion it drives a trial code to the converter's DAC and resolves one result bit per tick, most significant bit first, from a single comparator input. It also drives the analog multiplexer select.

Software first sets the enable input. It then picks the trigger source, the prescaler value, one-shot or continuous operation, and the channel. It starts a conversion and waits for the done pulse, after which it reads the result. In continuous mode the sequencer restarts by itself each time a conversion completes, until continuous mode is cleared or the enable is dropped.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset the block is disabled. While `en_i` is 0 every start request is ignored and `busy_o` stays 0. Dropping `en_i` during a conversion clears `busy_o` one cycle later, and no done pulse follows.
- R2: A conversion lasts exactly 16*(N+1) system clock cycles. It runs from the edge that sets `busy_o` to the edge that raises `done_o`. N is `presc_i` (0 to 15), captured when the conversion starts.
- R3: With `ext_sel_i` = 0, a one-cycle pulse on `start_wr_i` while idle and enabled starts a conversion, and `busy_o` reads 1 after the next edge. With `ext_sel_i` = 1, `start_wr_i` has no effect.
- R4: With `ext_sel_i` = 1, a high-to-low transition on `ext_start_n_i` starts a conversion, and `busy_o` becomes 1 on the third rising edge after the pin falls. A pin held low starts only one conversion in one-shot mode.
- R5: `busy_o` is 1 for the whole conversion. In one-shot mode it returns to 0 on the same edge that raises `done_o`. Start requests made while `busy_o` is 1, including one made in the completion cycle, are ignored.
- R6: `done_o` is a single-cycle pulse. `result_o` takes its new value on the edge that raises `done_o` and holds otherwise. Its reset value is 0.
- R7: The comparator input `cmp_i` is 1 when the sampled input is at or above `dac_code_o`. Under an ideal comparator the result equals the input code, for every code from 0 to 1023.
- R8: With `cont_i` = 1, the edge that completes a conversion immediately starts the next one. `busy_o` stays 1 and `done_o` pulses every 16*(N+1) cycles. Clearing `cont_i` lets the current conversion finish and then stop.
- R9: `mux_sel_o` takes the value of `chan_i` (0 to 7) when each conversion starts, including each automatic restart. A change of `chan_i` during a conversion does not affect `mux_sel_o` until the next start.
- R10: After reset, `busy_o`, `done_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| start_wr_i | input | 1 | One-cycle pulse: software wrote 1 to the start/busy bit |
| cont_i | input | 1 | 1 = continuous mode, 0 = one-shot |
| ext_sel_i | input | 1 | 1 = start from external pin, 0 = start from software |
| presc_i | input | 4 | Prescaler N; conversion clock = system clock / (N+1) |
| ext_start_n_i | input | 1 | Asynchronous active-low external start pin |
| chan_i | input | 3 | Requested input channel |
| cmp_i | input | 1 | Comparator: 1 when input >= trial code |
| dac_code_o | output | 10 | Trial code to the DAC |
| mux_sel_o | output | 3 | Channel select latched at conversion start |
| busy_o | output | 1 | Start/busy bit read value |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Last conversion result |

## Verification
Completion of a conversion and a new start request can fall in the same cycle. In one-shot mode the bench raises `start_wr_i` exactly for the completion edge, then expects `done_o` high, `busy_o` low and no conversion afterwards. In continuous mode the automatic restart lands on that same completion edge. The bench judges it by the spacing of the done pulses, by `busy_o` never dropping, and by the channel latched at the restart.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int ADC_RES_W   = 10;
    localparam int ADC_CH_W    = 3;
    localparam int ADC_PS_W    = 4;
    localparam int ADC_STEPS   = 16;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync
    import sar_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic fall_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    // history bit high, synchronized bit low
    assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];

    // R4
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/sar_clk_div.sv
module sar_clk_div
    import sar_pkg::*;
#(
    parameter int PS_W = ADC_PS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [PS_W-1:0] n_i,
    output logic            tick_o
);
    logic [PS_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == n_i);

    always_comb begin
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || n_i == '0));
endmodule

// File: rtl/sar_step_ctl.sv
module sar_step_ctl
    import sar_pkg::*;
#(
    parameter int RES_W = ADC_RES_W,
    parameter int CH_W  = ADC_CH_W,
    parameter int PS_W  = ADC_PS_W,
    parameter int STEPS = ADC_STEPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             tick_i,
    input  logic             cmp_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [PS_W-1:0]  presc_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] result_o,
    output logic [CH_W-1:0]  chan_o,
    output logic [PS_W-1:0]  presc_o
);
    localparam int STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_LSB   = STEP_W'(RES_W);
    localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(STEPS - 1);
    localparam logic [RES_W-1:0]  MSB_ONLY   = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [RES_W-1:0]  trial;
        logic [RES_W-1:0]  result;
        logic [CH_W-1:0]   chan;
        logic [PS_W-1:0]   presc;
    } st_t;

    st_t st_d, st_q;
    logic [RES_W-1:0] mask;

    always_comb begin
        mask = RES_W'(1) << (RES_W - int'(st_q.step));
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!en_i) begin
            st_d.busy = 1'b0;
            st_d.step = '0;
        end else if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.step  = '0;
                st_d.trial = MSB_ONLY;
                st_d.chan  = chan_i;
                st_d.presc = presc_i;
            end
        end else if (tick_i) begin
            if (st_q.step >= STEP_FIRST && st_q.step <= STEP_LSB) begin
                if (!cmp_i) st_d.trial = st_q.trial & ~mask;
                if (st_q.step != STEP_LSB) st_d.trial = st_d.trial | (mask >> 1);
            end
            if (st_q.step == STEP_LAST) begin
                st_d.result = st_q.trial;
                st_d.done   = 1'b1;
                if (cont_i) begin
                    st_d.step  = '0;
                    st_d.trial = MSB_ONLY;
                    st_d.chan  = chan_i;
                    st_d.presc = presc_i;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign trial_o  = st_q.trial;
    assign result_o = st_q.result;
    assign chan_o   = st_q.chan;
    assign presc_o  = st_q.presc;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    // R9
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !done_o) |-> $stable(chan_o));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W = ADC_RES_W,
    parameter int CH_W  = ADC_CH_W,
    parameter int PS_W  = ADC_PS_W,
    parameter int STEPS = ADC_STEPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_wr_i,
    input  logic             cont_i,
    input  logic             ext_sel_i,
    input  logic [PS_W-1:0]  presc_i,
    input  logic             ext_start_n_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic [CH_W-1:0]  mux_sel_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    logic ext_fall, start_req, tick;
    logic [PS_W-1:0] presc_run;

    sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n_i(ext_start_n_i), .fall_o(ext_fall)
    );

    assign start_req = en_i & (ext_sel_i ? ext_fall : start_wr_i);

    sar_clk_div #(.PS_W(PS_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(busy_o), .n_i(presc_run), .tick_o(tick)
    );

    sar_step_ctl #(.RES_W(RES_W), .CH_W(CH_W), .PS_W(PS_W), .STEPS(STEPS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_req),
        .cont_i(cont_i), .tick_i(tick), .cmp_i(cmp_i), .chan_i(chan_i),
        .presc_i(presc_i), .busy_o(busy_o), .done_o(done_o),
        .trial_o(dac_code_o), .result_o(result_o), .chan_o(mux_sel_o),
        .presc_o(presc_run)
    );

    // R1
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_o);
    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_req));
    // R5
    no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tick);
endmodule

// File: tb/sim_adc_sar_seq.sv
module sim_adc_sar_seq;
    localparam int CLK_PER = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, sw = 0, cont = 0, xsel = 0, xpin = 1;
    logic [3:0] presc = 0;
    logic [2:0] chan = 0;
    logic [9:0] vin = 0;
    logic [9:0] dac, res;
    logic [2:0] msel;
    logic busy, done, cmp;
    int n_chk = 0, n_err = 0;

    always #(CLK_PER/2) clk = ~clk;
    assign cmp = (vin >= dac);

    adc_sar_seq u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .start_wr_i(sw), .cont_i(cont),
        .ext_sel_i(xsel), .presc_i(presc), .ext_start_n_i(xpin), .chan_i(chan),
        .cmp_i(cmp), .dac_code_o(dac), .mux_sel_o(msel), .busy_o(busy),
        .done_o(done), .result_o(res)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done(output int k);
        k = 1;
        while (!done && k < 600) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic oneshot(input int v, input int n, input int ch, input bit full);
        int k;
        vin = 10'(v); presc = 4'(n); chan = 3'(ch); sw = 1;
        @(negedge clk);
        sw = 0;
        if (full) begin
            chk(busy == 1, "R3 busy after write", int'(busy), 1);
            chk(msel == 3'(ch), "R9 mux select", int'(msel), ch);
        end
        wait_done(k);
        if (full) begin
            chk(k == 16*(n+1)+1, "R2 conversion length", k, 16*(n+1)+1);
            chk(busy == 0, "R5 busy clears with done", int'(busy), 0);
        end
        chk(res == 10'(v), "R7 result code", int'(res), v);
        @(negedge clk);
        if (full) chk(done == 0, "R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        #(CLK_PER*190000);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        int k;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset values
        chk(busy == 0, "R10 busy reset", int'(busy), 0);
        chk(done == 0, "R10 done reset", int'(done), 0);
        chk(res == 0, "R10 result reset", int'(res), 0);

        // R1 start ignored while disabled
        sw = 1; @(negedge clk); sw = 0;
        repeat (4) @(negedge clk);
        chk(busy == 0, "R1 disabled ignores start", int'(busy), 0);
        chk(res == 0, "R1 result untouched", int'(res), 0);

        en = 1;
        @(negedge clk);
        // R2 prescaler sweep
        for (int n = 0; n < 16; n++) oneshot((n * 67 + 5) % 1024, n, n % 8, 1);

        // R7 all codes
        for (int v = 0; v < 1024; v++) oneshot(v, 0, v % 8, 0);

        // R3 software start ignored with external select
        xsel = 1; sw = 1; @(negedge clk); sw = 0;
        repeat (4) @(negedge clk);
        chk(busy == 0, "R3 write ignored on ext select", int'(busy), 0);

        // R4 external falling edge, held low
        vin = 10'd700; presc = 0; chan = 3;
        xpin = 0;
        k = 0;
        while (!busy && k < 20) begin @(negedge clk); k++; end
        chk(k == 3, "R4 sync latency", k, 3);
        wait_done(k);
        chk(res == 10'd700, "R4 ext result", int'(res), 700);
        repeat (40) @(negedge clk);
        chk(busy == 0, "R4 held low no restart", int'(busy), 0);
        xpin = 1; repeat (3) @(negedge clk);
        xsel = 0;

        // R5 start request coinciding with completion edge
        vin = 10'd321; presc = 1; sw = 1;
        @(negedge clk); sw = 0;
        for (int i = 1; i < 32; i++) @(negedge clk);
        sw = 1;
        @(negedge clk); sw = 0;
        chk(done == 1, "R5 done at completion", int'(done), 1);
        chk(busy == 0, "R5 busy low at completion", int'(busy), 0);
        @(negedge clk);
        chk(busy == 0, "R5 coincident start ignored", int'(busy), 0);

        // R1 abort by disable
        sw = 1; @(negedge clk); sw = 0;
        repeat (5) @(negedge clk);
        en = 0; @(negedge clk);
        chk(busy == 0, "R1 abort clears busy", int'(busy), 0);
        en = 1;
        repeat (40) @(negedge clk);
        chk(res == 10'd321, "R1 no result after abort", int'(res), 321);

        // R8 continuous mode, R9 channel change mid-run
        cont = 1; presc = 1; chan = 2; vin = 10'd100; sw = 1;
        @(negedge clk); sw = 0;
        wait_done(k);
        chk(k == 33, "R8 first period", k, 33);
        chk(res == 10'd100, "R8 first result", int'(res), 100);
        chk(busy == 1, "R8 busy kept at restart", int'(busy), 1);
        vin = 10'd900;
        @(negedge clk);
        repeat (10) @(negedge clk);
        chan = 5;
        repeat (5) @(negedge clk);
        chk(msel == 3'd2, "R9 mux held mid conversion", int'(msel), 2);
        k = 17;
        while (!done && k < 200) begin
            chk(busy == 1, "R8 busy stays high", int'(busy), 1);
            @(negedge clk); k++;
        end
        chk(k == 33, "R8 restart period", k, 33);
        chk(res == 10'd900, "R8 second result", int'(res), 900);
        chk(msel == 3'd5, "R9 new channel at restart", int'(msel), 5);
        @(negedge clk);
        cont = 0;
        wait_done(k);
        chk(k == 32, "R8 last period", k, 32);
        chk(busy == 0, "R8 stops after cont cleared", int'(busy), 0);
        repeat (40) @(negedge clk);
        chk(busy == 0, "R8 stays idle", int'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule